// File: doc/BRIEF.md
# Slave Serial Result Readout with Cascade Forwarding

This block returns an 18-bit conversion result to a host that supplies its own serial clock. The host's clock is oversampled by the fast system clock through a two-stage synchroniser, so all logic runs in the system clock domain. A conversion ends when the busy input falls. At that point the result word is copied into an internal shift register, and its MSB is driven on the serial output at once. The host then moves the word out MSB first, one bit per clock period.

Several devices can share one data line. Each device samples the serial output of the device upstream of it on the clock edge opposite the one it shifts on. It feeds that bit into the bottom of its own register. Once this device's LSB has gone out, the upstream word follows with no gap. A polarity input chooses which host clock edge shifts. A sticky flag records any host clock edge seen while a conversion is in progress.

The host runs each clock period as a sampling edge followed by a shifting edge. Between bursts it parks the clock at the level the shifting edge leaves behind.

Top module: `sr_readout_top`

## Requirements
- R1: After synchronous reset, `sdout` is 0 and `edge_err` is 0.
- R2: When `busy` goes from 1 to 0, the block loads `result` on the next system clock, and from then on `sdout` shows `result[17]` before any host clock edge.
- R3: With `sclk_inv` = 0, every rising edge of `sclk` advances the word by one bit, MSB first. After k shifting edges, `sdout` equals `result[17-k]` for k from 0 to 17.
- R4: On every sampling edge (falling when `sclk_inv` = 0), `chain_in` is captured and later enters the bottom of the register. After 18 shifting edges the upstream MSB appears on `sdout`. After 18+j edges, `sdout` shows the upstream bit `X[17-j]` that `chain_in` carried before the (j+1)-th shifting edge.
- R5: Host clock edges shift and sample only while `slave_en` is 1 and both `cs_n` and `rd_n` are 0. At other times `sdout` and the shift position hold, and shifting resumes from the same bit afterwards.
- R6: With `sclk_inv` = 1, falling edges shift and rising edges sample, with otherwise identical behaviour.
- R7: A synchronised `sclk` edge of either direction while `busy` is 1 and `slave_en` is 1 sets `edge_err`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst | input | 1 | Synchronous active-high reset |
| slave_en | input | 1 | 1 selects the externally clocked readout |
| sclk_inv | input | 1 | 0: rising edge shifts; 1: falling edge shifts |
| sclk | input | 1 | Host serial clock, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| busy | input | 1 | High during conversion; falling edge loads the result |
| result | input | 18 | Conversion result word |
| chain_in | input | 1 | Serial data from the upstream device |
| sdout | output | 1 | Serial data out |
| edge_err | output | 1 | Sticky flag: host clock edge during conversion |

## Verification
The hardest case to reach is the seam where this device's LSB gives way to the upstream MSB. That bit is captured on a sampling edge before the first shift, and it only appears 18 shifting edges later. The bench acts as the upstream device: it drives `chain_in` with a second random word in step with the host clock. It checks all 40 output positions, for both polarities. Random pauses on `cs_n` or `rd_n` fall in mid-word, including near the seam, to show that the position is kept across a freeze.

// File: rtl/sr_pkg.sv
package sr_pkg;

    localparam int unsigned DATA_W      = 18;
    localparam int unsigned SYNC_STAGES = 2;

    typedef struct packed {
        logic shift;   // edge that moves the word
        logic sample;  // opposite edge, captures chain input
        logic any;     // either edge
    } sclk_ev_t;

    function automatic sclk_ev_t pick_edges(logic rise, logic fall, logic inv);
        sclk_ev_t ev;
        ev.shift  = inv ? fall : rise;
        ev.sample = inv ? rise : fall;
        ev.any    = rise | fall;
        return ev;
    endfunction

endpackage

// File: rtl/sr_sclk_sync.sv
module sr_sclk_sync
    import sr_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk,
    input  logic     inv,
    output sclk_ev_t ev
);
    // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its previous value
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-1:0], sclk};
    end

    logic rise, fall;
    always_comb begin
        rise = pipe[STAGES-1] & ~pipe[STAGES];
        fall = ~pipe[STAGES-1] & pipe[STAGES];
        ev   = pick_edges(rise, fall, inv);
    end

endmodule

// File: rtl/sr_shift_chain.sv
module sr_shift_chain
    import sr_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         active,
    input  sclk_ev_t     ev,
    input  logic         chain_in,
    output logic         sdout
);
    logic [W-1:0] sh;
    logic         pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            pend <= 1'b0;
        end else begin
            if (load)
                sh <= load_word;
            else if (active && ev.shift)
                sh <= {sh[W-2:0], pend};
            if (active && ev.sample)
                pend <= chain_in;
        end
    end

    assign sdout = sh[W-1];

endmodule

// File: rtl/sr_err_flag.sv
module sr_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
    end
endmodule

// File: rtl/sr_readout_top.sv
module sr_readout_top
    import sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slave_en,
    input  logic              sclk_inv,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              busy,
    input  logic [DATA_W-1:0] result,
    input  logic              chain_in,
    output logic              sdout,
    output logic              edge_err
);
    sclk_ev_t ev;
    logic     busy_q;
    logic     load;
    logic     active;

    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= busy;
    end

    assign load   = busy_q & ~busy;
    assign active = slave_en & ~cs_n & ~rd_n;

    sr_sclk_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .inv  (sclk_inv),
        .ev   (ev)
    );

    sr_shift_chain #(.W(DATA_W)) shift_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_word (result),
        .active    (active),
        .ev        (ev),
        .chain_in  (chain_in),
        .sdout     (sdout)
    );

    sr_err_flag err_i (
        .clk  (clk),
        .rst  (rst),
        .set  (slave_en & busy & ev.any),
        .flag (edge_err)
    );

endmodule

// File: rtl/sr_readout_chk.sv
module sr_readout_chk #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic         slave_en,
    input logic         cs_n,
    input logic         rd_n,
    input logic         busy,
    input logic [W-1:0] result,
    input logic         sdout,
    input logic         edge_err
);
    // R2: falling busy loads the word and exposes its MSB
    a_r2_load_msb: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |=> (sdout == $past(result[W-1])));

    // R5: no shift while the read path is closed
    a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
        ((cs_n || rd_n || !slave_en) && !$fell(busy)) |=> $stable(sdout));

    // R7: flag is sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        edge_err |=> edge_err);

    // R7: flag only rises after a cycle with busy high
    a_r7_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(edge_err) |-> $past(busy));

    // R7: flag only rises in slave mode
    a_r7_mode: assert property (@(posedge clk) disable iff (rst)
        $rose(edge_err) |-> $past(slave_en));
endmodule

bind sr_readout_top sr_readout_chk #(.W(sr_pkg::DATA_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .slave_en (slave_en),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .busy     (busy),
    .result   (result),
    .sdout    (sdout),
    .edge_err (edge_err)
);

// File: tb/sr_readout_top_tb_top.sv
module sr_readout_top_tb_top;
    logic        clk = 1'b0;
    logic        rst, slave_en, sclk_inv, sclk, cs_n, rd_n, busy, chain_in;
    logic [17:0] result;
    logic        sdout, edge_err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    sr_readout_top dut_i (
        .clk(clk), .rst(rst), .slave_en(slave_en), .sclk_inv(sclk_inv),
        .sclk(sclk), .cs_n(cs_n), .rd_n(rd_n), .busy(busy),
        .result(result), .chain_in(chain_in), .sdout(sdout), .edge_err(edge_err)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // expected serial bit after k shifting edges: own word, then upstream word
    function automatic logic exp_bit(logic [17:0] d, logic [17:0] x, int k);
        if (k < 18) return d[17-k];
        if (k < 36) return x[35-k];
        return 1'b0;
    endfunction

    function automatic logic up_bit(logic [17:0] x, int k);
        return (k < 18) ? x[17-k] : 1'b0;
    endfunction

    task automatic set_edge(logic lvl);
        sclk = lvl;
        wait_clk(6);
    endtask

    task automatic set_inv(logic v);
        cs_n = 1'b1;
        sclk_inv = v;
        sclk = ~v;
        wait_clk(6);
    endtask

    task automatic convert(logic [17:0] d);
        cs_n = 1'b1;
        rd_n = 1'b1;
        result = d;
        busy = 1'b1;
        wait_clk(3);
        busy = 1'b0;
        wait_clk(3);
        chk("R2", sdout, d[17]);
    endtask

    // 40 host clock periods; optional freeze before period 'pause'
    task automatic run_word(logic [17:0] d, logic [17:0] x, int pause);
        cs_n = 1'b0;
        rd_n = 1'b0;
        for (int k = 0; k < 40; k++) begin
            chain_in = up_bit(x, k);
            if (k == pause) begin
                if (k % 2 == 0) cs_n = 1'b1; else rd_n = 1'b1;
                set_edge(sclk_inv);
                set_edge(~sclk_inv);
                chk("R5", sdout, exp_bit(d, x, k));
                cs_n = 1'b0;
                rd_n = 1'b0;
            end
            set_edge(sclk_inv);    // sampling edge
            set_edge(~sclk_inv);   // shifting edge
            if (k < 18)
                chk(sclk_inv ? "R6" : "R3", sdout, exp_bit(d, x, k + 1));
            else
                chk("R4", sdout, exp_bit(d, x, k + 1));
        end
        cs_n = 1'b1;
        rd_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; slave_en = 1'b1; sclk_inv = 1'b0; sclk = 1'b1;
        cs_n = 1'b1; rd_n = 1'b1; busy = 1'b0; chain_in = 1'b0; result = '0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(6);
        chk("R1", sdout, 1'b0);
        chk("R1", edge_err, 1'b0);

        // directed: rising-edge shift, full cascade
        convert(18'h2A5C3);
        run_word(18'h2A5C3, 18'h1F0F0, -1);

        // directed: falling-edge shift with freeze near the seam
        set_inv(1'b1);
        convert(18'h35A96);
        run_word(18'h35A96, 18'h2C3A5, 17);

        // slave mode off: host clock ignored
        set_inv(1'b0);
        convert(18'h3FFFF);
        slave_en = 1'b0;
        cs_n = 1'b0; rd_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            set_edge(1'b0);
            set_edge(1'b1);
        end
        chk("R5", sdout, 1'b1);
        cs_n = 1'b1; rd_n = 1'b1;
        slave_en = 1'b1;
        wait_clk(2);

        // random words, polarity and pause point
        void'($urandom(32'd4242));
        for (int n = 0; n < 6; n++) begin
            logic [17:0] d, x;
            d = 18'($urandom);
            x = 18'($urandom);
            set_inv(1'($urandom));
            convert(d);
            run_word(d, x, int'($urandom % 40));
        end
        chk("R7", edge_err, 1'b0);

        // clock edge during conversion
        busy = 1'b1;
        wait_clk(3);
        set_edge(~sclk);
        chk("R7", edge_err, 1'b1);
        busy = 1'b0;
        wait_clk(3);
        set_edge(~sclk);
        chk("R7", edge_err, 1'b1);
        rst = 1'b1;
        wait_clk(2);
        rst = 1'b0;
        wait_clk(6);
        chk("R7", edge_err, 1'b0);
        chk("R1", sdout, 1'b0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule